// File: doc/BRIEF.md
# Half to Single Precision Widener

This block turns a 16-bit binary16 value into the equal 32-bit binary32 value. A word goes in with a valid strobe. One clock later the block gives out the widened word, an output valid and a three-bit class code. Every binary16 value can be written exactly in binary32, so the block never rounds. Subnormal inputs come out as normal single-precision numbers. A leading-zero count and a left shift renormalize them.

A mode input picks between two readings of the top exponent code. In the standard reading, exponent 31 holds infinities and NaNs. In the alternative reading, exponent 31 is one more binade of normal numbers, which reach 131008. The sign is always kept, and every NaN comes out quiet.

Top module: `hcv_widen`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` on the next rising edge, even if `in_valid` is high at that edge.
- R2: `out_valid` is high in the cycle after an edge at which `in_valid` was high, and low after an idle edge. The converted word and class appear with the same one-cycle latency.
- R3: At an edge where `in_valid` is low, `out_single` and `out_class` keep their values, whatever `in_half` and `alt_mode` hold.
- R4: An input with exponent field (bits 14:10) equal to 0 and fraction field (bits 9:0) equal to 0 gives a signed zero: output bit 31 equals input bit 15 and bits 30:0 are 0. The class is 0 (zero).
- R5: An input with exponent 0 and a nonzero fraction gives a normal binary32 value. Its exponent field (bits 30:23) is 112 minus the number of leading zeros of the 10-bit fraction. Its fraction field (bits 22:0) is the remaining fraction bits, left-aligned after the top 1 is dropped. The class is 1 (subnormal). For example, 0x0001 gives 0x33800000 and 0x03FF gives 0x387FC000.
- R6: An input with exponent 1 to 30 gives output exponent = input exponent + 112, and the 10-bit fraction followed by 13 zeros. The class is 2 (normal). For example, 0x3C00 gives 0x3F800000, 0x7BFF gives 0x477FE000 and 0xC000 gives 0xC0000000.
- R7: In standard mode (`alt_mode` = 0), exponent 31 with a zero fraction gives signed infinity: exponent 255 and fraction 0. The class is 3 (infinity). For example, 0xFC00 gives 0xFF800000.
- R8: In standard mode, exponent 31 with a nonzero fraction gives a NaN:
  - exponent 255, with output bit 22 set to 1;
  - input fraction bits 8:0 placed in output bits 21:13, and output bits 12:0 set to 0;
  - class 4 (NaN).
- R9: In alternative mode (`alt_mode` = 1), exponent 31 is a normal number: output exponent 143, fraction placed as in R6, class 2. No input in this mode gives class 3 or 4. For example, 0x7FFF gives 0x47FFE000.
- R10: Output bit 31 always equals input bit 15, for every encoding and in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input word is present this cycle |
| in_half | input | 16 | binary16 input value |
| alt_mode | input | 1 | 1 reads exponent 31 as normal numbers |
| out_valid | output | 1 | Registered valid, one cycle after `in_valid` |
| out_single | output | 32 | Registered binary32 result |
| out_class | output | 3 | Class: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 NaN |

## Verification
The only internal state is the output register, so a wrong captured value shows at the ports one cycle after the word that caused it. The bench compares every standard-mode encoding, and the alternative-mode ranges around exponents 0 and 31, against a separate bit-level model. A fault in the leading-zero count or in the exponent rebias therefore shows on the first word it touches. A wrong capture enable shows in the idle cycle after a conversion, as a changed word, or as a valid one cycle early or late.

// File: rtl/hcv_pkg.sv
package hcv_pkg;

  // Class code carried beside each widened word
  typedef enum logic [2:0] {
    HCV_ZERO = 3'd0,
    HCV_SUB  = 3'd1,
    HCV_NORM = 3'd2,
    HCV_INF  = 3'd3,
    HCV_NAN  = 3'd4
  } hcv_class_e;

endpackage

// File: rtl/hcv_lzc.sv
module hcv_lzc #(
  parameter int W = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);

  // Scan from the bottom bit up, so the highest set bit is the last to write
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end

  // R5
  always_comb begin
    if (vec != '0) begin
      lzc_lead_one_chk: assert (vec[W - 1 - int'(count)] == 1'b1);
    end
  end

endmodule

// File: rtl/hcv_decode.sv
module hcv_decode
  import hcv_pkg::*;
#(
  parameter int HEW = 5,
  parameter int HFW = 10
) (
  input  logic [HEW+HFW:0] half,
  input  logic             alt_mode,
  output logic             sign,
  output logic [HEW-1:0]   exp_f,
  output logic [HFW-1:0]   frac_f,
  output hcv_class_e       cls
);

  assign sign   = half[HEW+HFW];
  assign exp_f  = half[HEW+HFW-1 -: HEW];
  assign frac_f = half[HFW-1:0];

  logic exp_zero;
  logic exp_full;
  logic frac_zero;

  assign exp_zero  = (exp_f == '0);
  assign exp_full  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  always_comb begin
    if (exp_zero) begin
      cls = frac_zero ? HCV_ZERO : HCV_SUB;
    end else if (exp_full && !alt_mode) begin
      cls = frac_zero ? HCV_INF : HCV_NAN;
    end else begin
      cls = HCV_NORM;
    end
  end

endmodule

// File: rtl/hcv_assemble.sv
module hcv_assemble
  import hcv_pkg::*;
#(
  parameter int HEW = 5,
  parameter int HFW = 10,
  parameter int SEW = 8,
  parameter int SFW = 23,
  localparam int CW = $clog2(HFW + 1),
  localparam int SW = 1 + SEW + SFW
) (
  input  logic           sign,
  input  logic [HEW-1:0] exp_f,
  input  logic [HFW-1:0] frac_f,
  input  hcv_class_e     cls,
  input  logic [CW-1:0]  lzc,
  output logic [SW-1:0]  word
);

  localparam int HBIAS = (1 << (HEW - 1)) - 1;
  localparam int SBIAS = (1 << (SEW - 1)) - 1;
  localparam int PAD   = SFW - HFW;
  localparam logic [SEW-1:0] REBIAS = SEW'(SBIAS - HBIAS);

  logic [CW:0]    shamt;
  logic [HFW-1:0] sub_frac;
  logic [SEW-1:0] sub_exp;
  logic [SEW-1:0] norm_exp;

  assign shamt    = {1'b0, lzc} + (CW+1)'(1);
  assign sub_frac = frac_f << shamt;
  assign sub_exp  = REBIAS - SEW'(lzc);
  assign norm_exp = REBIAS + SEW'(exp_f);

  always_comb begin
    unique case (cls)
      HCV_ZERO: word = {sign, {(SW-1){1'b0}}};
      HCV_SUB:  word = {sign, sub_exp, sub_frac, {PAD{1'b0}}};
      HCV_INF:  word = {sign, {SEW{1'b1}}, {SFW{1'b0}}};
      HCV_NAN:  word = {sign, {SEW{1'b1}}, 1'b1, frac_f[HFW-2:0], {PAD{1'b0}}};
      default:  word = {sign, norm_exp, frac_f, {PAD{1'b0}}};
    endcase
  end

  // R5
  always_comb begin
    if (cls == HCV_SUB) begin
      sub_exp_range_chk: assert ((word[SW-2 -: SEW] <= REBIAS) &&
                                 (word[SW-2 -: SEW] >= REBIAS - SEW'(HFW - 1)));
    end
  end

endmodule

// File: rtl/hcv_widen.sv
module hcv_widen
  import hcv_pkg::*;
#(
  parameter int HEW = 5,
  parameter int HFW = 10,
  parameter int SEW = 8,
  parameter int SFW = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [HEW+HFW:0]   in_half,
  input  logic               alt_mode,
  output logic               out_valid,
  output logic [SEW+SFW:0]   out_single,
  output logic [2:0]         out_class
);

  localparam int CW = $clog2(HFW + 1);
  localparam int SW = 1 + SEW + SFW;

  logic           d_sign;
  logic [HEW-1:0] d_exp;
  logic [HFW-1:0] d_frac;
  hcv_class_e     d_cls;
  logic [CW-1:0]  d_lzc;
  logic [SW-1:0]  d_word;

  hcv_decode #(.HEW(HEW), .HFW(HFW)) u_decode (
    .half     (in_half),
    .alt_mode (alt_mode),
    .sign     (d_sign),
    .exp_f    (d_exp),
    .frac_f   (d_frac),
    .cls      (d_cls)
  );

  hcv_lzc #(.W(HFW)) u_lzc (
    .vec   (d_frac),
    .count (d_lzc)
  );

  hcv_assemble #(.HEW(HEW), .HFW(HFW), .SEW(SEW), .SFW(SFW)) u_assemble (
    .sign   (d_sign),
    .exp_f  (d_exp),
    .frac_f (d_frac),
    .cls    (d_cls),
    .lzc    (d_lzc),
    .word   (d_word)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // Data registers need no reset: out_valid qualifies them
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_single <= d_word;
      out_class  <= d_cls;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_single) && $stable(out_class)));

  // R10
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_single[SW-1] == $past(in_half[HEW+HFW])));

  // R9
  alt_no_special_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && alt_mode) |=> ((out_class != 3'(HCV_INF)) && (out_class != 3'(HCV_NAN))));

  // R8
  nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 3'(HCV_NAN)) |->
      ((out_single[SW-2 -: SEW] == '1) && out_single[SFW-1]));

  // R7
  inf_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 3'(HCV_INF)) |->
      ((out_single[SW-2 -: SEW] == '1) && (out_single[SFW-1:0] == '0)));

endmodule

// File: tb/hcv_widen_bench.sv
`timescale 1ns/1ps
module hcv_widen_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] in_half;
  logic        alt_mode;
  logic        out_valid;
  logic [31:0] out_single;
  logic [2:0]  out_class;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hcv_widen u_hcv_widen (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .alt_mode   (alt_mode),
    .out_valid  (out_valid),
    .out_single (out_single),
    .out_class  (out_class)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bit-level model built from the requirements
  function automatic void model(input logic [15:0] h, input logic alt,
                                output logic [31:0] w, output logic [2:0] c);
    logic        s;
    logic [4:0]  e;
    logic [9:0]  f;
    logic [10:0] m;
    int          ex;
    s = h[15]; e = h[14:10]; f = h[9:0];
    if (e == 0 && f == 0) begin
      w = {s, 31'b0}; c = 3'd0;
    end else if (e == 0) begin
      m = {1'b0, f}; ex = 113;
      for (int k = 0; k < 11; k++) begin
        if (!m[10]) begin m = m << 1; ex = ex - 1; end
      end
      w = {s, 8'(ex), m[9:0], 13'b0}; c = 3'd1;
    end else if (e == 5'd31 && !alt) begin
      if (f == 0) begin w = {s, 8'hFF, 23'b0}; c = 3'd3; end
      else begin w = {s, 8'hFF, 1'b1, f[8:0], 13'b0}; c = 3'd4; end
    end else begin
      w = {s, 8'(32'(e) + 112), f, 13'b0}; c = 3'd2;
    end
  endfunction

  function automatic string tag_of(input logic [2:0] c, input logic alt,
                                   input logic [15:0] h);
    if (alt && h[14:10] == 5'd31) return "R9";
    case (c)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [15:0] h, input logic alt);
    @(negedge clk);
    in_half = h; alt_mode = alt; in_valid = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic conv(input logic [15:0] h, input logic alt,
                      input logic [31:0] ew, input logic [2:0] ec, input string tag);
    apply(h, alt);
    chk(tag, "word", out_single, ew);
    chk(tag, "class", {29'b0, out_class}, {29'b0, ec});
    chk("R2", "valid", {31'b0, out_valid}, 32'd1);
    chk("R10", "sign", {31'b0, out_single[31]}, {31'b0, h[15]});
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_half = '0; alt_mode = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "valid in reset", {31'b0, out_valid}, 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_directed_std;
    conv(16'h0000, 1'b0, 32'h00000000, 3'd0, "R4");
    conv(16'h8000, 1'b0, 32'h80000000, 3'd0, "R4");
    conv(16'h0001, 1'b0, 32'h33800000, 3'd1, "R5");
    conv(16'h03FF, 1'b0, 32'h387FC000, 3'd1, "R5");
    conv(16'h8200, 1'b0, 32'hB8000000, 3'd1, "R5");
    conv(16'h0400, 1'b0, 32'h38800000, 3'd2, "R6");
    conv(16'h3C00, 1'b0, 32'h3F800000, 3'd2, "R6");
    conv(16'h3555, 1'b0, 32'h3EAAA000, 3'd2, "R6");
    conv(16'h7BFF, 1'b0, 32'h477FE000, 3'd2, "R6");
    conv(16'hC000, 1'b0, 32'hC0000000, 3'd2, "R6");
    conv(16'h7C00, 1'b0, 32'h7F800000, 3'd3, "R7");
    conv(16'hFC00, 1'b0, 32'hFF800000, 3'd3, "R7");
    conv(16'h7C01, 1'b0, 32'h7FC02000, 3'd4, "R8");
    conv(16'h7E00, 1'b0, 32'h7FC00000, 3'd4, "R8");
    conv(16'hFD55, 1'b0, 32'hFFEAA000, 3'd4, "R8");
    conv(16'h7FFF, 1'b0, 32'h7FFFE000, 3'd4, "R8");
  endtask

  task automatic t_directed_alt;
    conv(16'h7C00, 1'b1, 32'h47800000, 3'd2, "R9");
    conv(16'h7FFF, 1'b1, 32'h47FFE000, 3'd2, "R9");
    conv(16'hFC00, 1'b1, 32'hC7800000, 3'd2, "R9");
    conv(16'h3C00, 1'b1, 32'h3F800000, 3'd2, "R9");
    conv(16'h0001, 1'b1, 32'h33800000, 3'd1, "R5");
  endtask

  task automatic t_hold;
    apply(16'h3C00, 1'b0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_half = 16'h7C01 + 16'(k); alt_mode = 1'b1;
      @(posedge clk);
      #1;
      chk("R3", "held word", out_single, 32'h3F800000);
      chk("R3", "held class", {29'b0, out_class}, 32'd2);
      chk("R2", "idle valid", {31'b0, out_valid}, 32'd0);
    end
  endtask

  task automatic t_reset_midstream;
    apply(16'h3C00, 1'b0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_half = 16'h4000;
    @(posedge clk);
    #1;
    chk("R1", "valid after reset edge", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R2", "valid after idle", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic sweep(input int lo, input int hi, input logic alt);
    logic [31:0] ew;
    logic [2:0]  ec;
    for (int i = lo; i <= hi; i++) begin
      apply(16'(i), alt);
      model(16'(i), alt, ew, ec);
      chk(tag_of(ec, alt, 16'(i)), "sweep word", out_single, ew);
      chk(tag_of(ec, alt, 16'(i)), "sweep class", {29'b0, out_class}, {29'b0, ec});
      chk("R10", "sweep sign", {31'b0, out_single[31]}, {31'b0, 1'(i >> 15)});
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    summary();
  end

  initial begin
    t_reset();
    t_directed_std();
    t_directed_alt();
    t_hold();
    t_reset_midstream();
    sweep(0, 65535, 1'b0);
    sweep(16'h0000, 16'h07FF, 1'b1);
    sweep(16'h7800, 16'h87FF, 1'b1);
    sweep(16'hF800, 16'hFFFF, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R2", "final idle valid", {31'b0, out_valid}, 32'd0);
    summary();
  end

endmodule